// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block derives the serial bus clock, and a set of timing strobes for the protocol engine, from the peripheral clock. Two small programmable counters run in cascade. The first divides the peripheral clock by A+1. The second divides that result by B+1 and produces a base tick. A fixed phase counter then counts 22 base ticks per serial clock period. The serial clock is low for the first 11 ticks and high for the last 11, so its frequency is the peripheral clock frequency divided by 22 × (A+1) × (B+1).

The same rate is used when the controller acts as a target on the bus. In that case the divided clock sets the sampling rate, so the divisors must be chosen to give a rate no slower than the fastest serial clock expected on the bus.

The divisor inputs come from a control register that resets to zero. The block keeps its own copy of them and takes a new setting only at a period boundary. The enable input starts the divider and stops it. Pad drivers, clock stretching and the bus protocol itself are handled by other blocks.

Top module: `sclk_two_stage_div`

## Requirements
- R1: During reset and right after it, `scl` is 1 and `base_tick`, `period_start`, `scl_rise`, `shift_strobe` and `sample_strobe` are all 0.
- R2: In every cycle after a rising clock edge at which `enable` was 0, `scl` is 1 and all five strobe outputs are 0.
- R3: While running, `base_tick` is high for one cycle in every M cycles, where M = (div_a+1)×(div_b+1). It is high in the last cycle of each group of M cycles counted from the start of a period.
- R4: The period is 22×M cycles long. `scl` is 0 for the first 11×M cycles of each period and 1 for the remaining 11×M cycles. The first period begins in the cycle after the first rising edge at which `enable` is sampled 1.
- R5: `period_start` is high only in the first cycle of each period, which is the first cycle in which `scl` is 0. `scl_rise` is high only in the first cycle in which `scl` is 1 within a period.
- R6: `shift_strobe` is high only in cycle 5×M of a period, the middle of the low phase. `sample_strobe` is high only in cycle 16×M, the middle of the high phase. Both cycles are counted from 0.
- R7: The divisor values present at the rising edge that ends the last cycle of a period set M for the next period. A change to div_a or div_b at any other point has no effect on the current period.
- R8: Dropping `enable` in the middle of a period stops the divider at once, as in R2. When `enable` is raised again, a new period starts with a full low phase and uses the divisors present at that edge.
- R9: The extreme settings work. With A=0 and B=0 the period is 22 cycles. With A=3 and B=63 the period is 5632 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the divider when 1; when 0 holds it idle with `scl` high |
| div_a | input | 2 | First-stage divisor A; divides by A+1 |
| div_b | input | 6 | Second-stage divisor B; divides by B+1 |
| base_tick | output | 1 | One-cycle pulse every (A+1)(B+1) cycles |
| scl | output | 1 | Serial clock level |
| period_start | output | 1 | First cycle of a serial clock period (falling edge) |
| scl_rise | output | 1 | First cycle of the high phase |
| shift_strobe | output | 1 | Middle of the low phase, for changing data |
| sample_strobe | output | 1 | Middle of the high phase, for sampling data |

## Verification
The hardest case to reach is a divisor change that lands in the last cycle of a period, together with an enable drop that cuts a period short. In both cases the setting the block uses differs from the one on its inputs at nearly every other moment. The bench runs a cycle-accurate behavioural model beside the design and changes the divisors and the enable at random cycles. With small divisors, periods are only a few dozen cycles long, so changes regularly land on a boundary. Directed runs add a change in the middle of a period, a mid-period enable drop, and the two extreme divisor settings.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

    // Divisor field widths and half-period length in base ticks.
    localparam int DIV_A_W    = 2;
    localparam int DIV_B_W    = 6;
    localparam int HALF_SLOTS = 11;

    // Live divisor copy plus running flag.
    typedef struct packed {
        logic               run;
        logic [DIV_A_W-1:0] a;
        logic [DIV_B_W-1:0] b;
    } sclk_cfg_t;

endpackage

// File: rtl/sclk_prescale.sv
// One programmable divide-by-(limit+1) stage, advanced by step.
module sclk_prescale #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         tick,
    output logic         at_zero
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        tick    = step && (st_q.cnt == limit);
        at_zero = (st_q.cnt == '0);
        if (clr) begin
            st_d.cnt = '0;
        end else if (step) begin
            if (st_q.cnt == limit) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sclk_phase_seq.sv
// Counts base ticks across one serial clock period and derives level and strobes.
module sclk_phase_seq #(
    parameter int HALF = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic adv,
    input  logic slot_first,
    output logic scl,
    output logic start,
    output logic rise,
    output logic shift,
    output logic sample,
    output logic wrap
);

    localparam int SLOTS = 2 * HALF;
    localparam int PH_W  = $clog2(SLOTS);
    localparam logic [PH_W-1:0] LAST_SLOT   = PH_W'(SLOTS - 1);
    localparam logic [PH_W-1:0] RISE_SLOT   = PH_W'(HALF);
    localparam logic [PH_W-1:0] SHIFT_SLOT  = PH_W'(HALF / 2);
    localparam logic [PH_W-1:0] SAMPLE_SLOT = PH_W'(HALF + HALF / 2);

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap   = adv && (st_q.ph == LAST_SLOT);
        scl    = !run || (st_q.ph >= RISE_SLOT);
        start  = slot_first && (st_q.ph == '0);
        rise   = slot_first && (st_q.ph == RISE_SLOT);
        shift  = slot_first && (st_q.ph == SHIFT_SLOT);
        sample = slot_first && (st_q.ph == SAMPLE_SLOT);
        if (clr) begin
            st_d.ph = '0;
        end else if (adv) begin
            if (wrap) begin
                st_d.ph = '0;
            end else begin
                st_d.ph = st_q.ph + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sclk_two_stage_div.sv
module sclk_two_stage_div
    import sclk_div_pkg::*;
#(
    parameter int A_W  = DIV_A_W,
    parameter int B_W  = DIV_B_W,
    parameter int HALF = HALF_SLOTS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic [A_W-1:0] div_a,
    input  logic [B_W-1:0] div_b,
    output logic           base_tick,
    output logic           scl,
    output logic           period_start,
    output logic           scl_rise,
    output logic           shift_strobe,
    output logic           sample_strobe
);

    typedef struct packed {
        logic           run;
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic           run_q;
    logic [A_W-1:0] div_a_q;
    logic [B_W-1:0] div_b_q;
    logic           clr;
    logic           tick_a, zero_a;
    logic           tick_b, zero_b;
    logic           wrap;
    logic           slot_first;

    assign run_q   = cfg_q.run;
    assign div_a_q = cfg_q.a;
    assign div_b_q = cfg_q.b;
    assign clr     = !enable;

    // Divisor copy: tracks inputs while idle, reloads only at a period boundary.
    always_comb begin
        cfg_d     = cfg_q;
        cfg_d.run = enable;
        if (!cfg_q.run || wrap) begin
            cfg_d.a = div_a;
            cfg_d.b = div_b;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    sclk_prescale #(.W(A_W)) u_stage_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .step    (run_q),
        .limit   (div_a_q),
        .tick    (tick_a),
        .at_zero (zero_a)
    );

    sclk_prescale #(.W(B_W)) u_stage_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .step    (tick_a),
        .limit   (div_b_q),
        .tick    (tick_b),
        .at_zero (zero_b)
    );

    assign base_tick  = tick_b;
    assign slot_first = run_q && zero_a && zero_b;

    sclk_phase_seq #(.HALF(HALF)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .run        (run_q),
        .adv        (tick_b),
        .slot_first (slot_first),
        .scl        (scl),
        .start      (period_start),
        .rise       (scl_rise),
        .shift      (shift_strobe),
        .sample     (sample_strobe),
        .wrap       (wrap)
    );

endmodule

// File: rtl/sclk_div_checker.sv
module sclk_div_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          run_q,
    input logic [DW-1:0] div_q,
    input logic          base_tick,
    input logic          scl,
    input logic          period_start,
    input logic          scl_rise,
    input logic          shift_strobe,
    input logic          sample_strobe
);

    assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl && !period_start && !base_tick));

    assert_tick_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        base_tick |-> run_q);

    assert_fall_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl) |-> period_start);

    assert_start_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> !scl);

    assert_rise_marked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl) && $past(enable)) |-> scl_rise);

    assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({period_start, scl_rise, shift_strobe, sample_strobe}));

    assert_div_only_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && !$stable(div_q)) |-> period_start);

endmodule

bind sclk_two_stage_div sclk_div_checker #(.DW(A_W + B_W)) u_sclk_div_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .run_q         (run_q),
    .div_q         ({div_a_q, div_b_q}),
    .base_tick     (base_tick),
    .scl           (scl),
    .period_start  (period_start),
    .scl_rise      (scl_rise),
    .shift_strobe  (shift_strobe),
    .sample_strobe (sample_strobe)
);

// File: tb/tb_sclk_two_stage_div.sv
`timescale 1ns/1ps
module tb_sclk_two_stage_div;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] div_a = '0;
    logic [5:0] div_b = '0;
    logic       base_tick, scl, period_start, scl_rise, shift_strobe, sample_strobe;

    int n_vec = 0;
    int n_bad = 0;

    // Behavioural model state
    bit active = 0;
    int pos = 0;
    int m = 1;

    always #4 clk = ~clk; // 125 MHz

    sclk_two_stage_div dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_a(div_a), .div_b(div_b),
        .base_tick(base_tick), .scl(scl), .period_start(period_start),
        .scl_rise(scl_rise), .shift_strobe(shift_strobe), .sample_strobe(sample_strobe)
    );

    function automatic int mult(input logic [1:0] a, input logic [5:0] b);
        return (int'(a) + 1) * (int'(b) + 1);
    endfunction

    task automatic cmp(input string tag, input string name, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b (active=%0b pos=%0d m=%0d)",
                     tag, name, act, exp, active, pos, m);
        end
    endtask

    task automatic check_outputs();
        if (!active) begin
            // R2: idle state
            cmp("R2", "scl", scl, 1'b1);
            cmp("R2", "strobes", base_tick | period_start | scl_rise | shift_strobe | sample_strobe, 1'b0);
        end else begin
            cmp("R4", "scl", scl, pos >= 11 * m);
            cmp("R3", "base_tick", base_tick, (pos % m) == m - 1);
            cmp("R5", "period_start", period_start, pos == 0);
            cmp("R5", "scl_rise", scl_rise, pos == 11 * m);
            cmp("R6", "shift_strobe", shift_strobe, pos == 5 * m);
            cmp("R6", "sample_strobe", sample_strobe, pos == 16 * m);
        end
    endtask

    // One cycle: sample at negedge, then drive next inputs and advance model (R7, R8).
    task automatic cycle(input bit e, input logic [1:0] na, input logic [5:0] nb);
        @(negedge clk);
        check_outputs();
        enable = e;
        div_a  = na;
        div_b  = nb;
        if (!e) begin
            active = 0;
        end else if (!active) begin
            active = 1; pos = 0; m = mult(na, nb);
        end else if (pos == 22 * m - 1) begin
            pos = 0; m = mult(na, nb);
        end else begin
            pos++;
        end
    endtask

    task automatic hold(input int n);
        for (int i = 0; i < n; i++) cycle(enable, div_a, div_b);
    endtask

    initial begin
        void'($urandom(32'h5C1D_0022));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        cmp("R1", "scl", scl, 1'b1);
        cmp("R1", "strobes", base_tick | period_start | scl_rise | shift_strobe | sample_strobe, 1'b0);
        rst_n = 1'b1;
        hold(4);
        // R9: minimum divisors, period 22
        cycle(1, 2'd0, 6'd0);
        hold(22 * 3);
        // R7: change divisors mid-period; old setting finishes the period
        hold(7);
        cycle(1, 2'd1, 6'd2);
        hold(22 * 6 * 3);
        // R8: drop enable mid-period, then restart with new divisors
        hold(40);
        cycle(0, 2'd2, 6'd1);
        hold(5);
        cycle(1, 2'd0, 6'd3);
        hold(22 * 4 * 2);
        // R9: maximum divisors, period 5632
        cycle(0, 2'd3, 6'd63);
        cycle(1, 2'd3, 6'd63);
        hold(5632 * 2 + 20);
        // Random mix
        for (int i = 0; i < 60000; i++) begin
            logic [1:0] na = div_a;
            logic [5:0] nb = div_b;
            bit e = enable;
            if ($urandom_range(0, 49) == 0) begin
                na = 2'($urandom_range(0, 3));
                nb = ($urandom_range(0, 9) == 0) ? 6'($urandom_range(0, 63)) : 6'($urandom_range(0, 5));
            end
            if ($urandom_range(0, 2999) == 0) e = !e;
            cycle(e, na, nb);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule